// File: doc/BRIEF.md
# Layer Sequencing Controller

This block walks a program of wide control words, one word per network operator, held in an on-chip memory with a one-cycle synchronous read. After a start request from the host link it reads the words in address order. It splits each word into an opcode and three operand fields, and it starts three worker units together: the input reader, the processing element and the output writer. Each unit receives a one-cycle valid pulse and its own field.

The controller then waits at a barrier. Each worker reports completion on its own done line, and the workers may finish in any order. The completions are held in a sticky mask. The next word is read only when every worker has reported. A word carrying the terminating opcode ends the program: no worker is started, a one-cycle finished pulse is raised and the controller waits for the next start request.

Top module: `layer_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, imem_rd_o, all three valid outputs and finished_o are low.
- R2: A start_i seen while idle makes the first read at address 0. Each later read uses the next address, one per word. A start_i seen while a program is running is ignored and does not restart the addresses.
- R3: With the default parameters the opcode sits in word bits [7:0], the reader field in [167:8], the processing-element field in [327:168] and the writer field in [487:328]. Each field is presented on its output while its valid is high.
- R4: For a non-terminating word, the three valid outputs go high together for exactly one cycle, two cycles after the cycle in which the word was read.
- R5: Done inputs may arrive in any order and at different times. The next read is issued in the cycle after the one in which the last outstanding done is seen. The next dispatch therefore follows the previous one by (latest done delay + 3) cycles.
- R6: A done input that arrives while no operation is outstanding (for example while idle) is ignored. No read, valid or finished output results from it.
- R7: A word whose opcode is 8'hFF produces no valid. finished_o pulses for one cycle, two cycles after that word is read, and the controller returns to idle and accepts a new start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request from the host link |
| imem_rd_o | output | 1 | Read enable to the control-word memory |
| imem_addr_o | output | ADDR_W (8) | Read address to the control-word memory |
| imem_data_i | input | INSTR_W (512) | Word returned one cycle after the read |
| rd_valid_o | output | 1 | Start pulse to the input reader |
| rd_field_o | output | FIELD_W (160) | Operand field for the input reader |
| pe_valid_o | output | 1 | Start pulse to the processing element |
| pe_field_o | output | FIELD_W (160) | Operand field for the processing element |
| wr_valid_o | output | 1 | Start pulse to the output writer |
| wr_field_o | output | FIELD_W (160) | Operand field for the output writer |
| rd_done_i | input | 1 | Completion from the input reader |
| pe_done_i | input | 1 | Completion from the processing element |
| wr_done_i | input | 1 | Completion from the output writer |
| finished_o | output | 1 | One-cycle pulse at the end of the program |

## Verification
Two events can coincide. The last worker's done can land in the same cycle as a done from another worker, and a start request can arrive in the same cycle as a done. Both are provoked from a delay table: one entry gives all three workers the same delay, the others stagger them, and a start pulse is injected partway through a program. Each case is judged at the ports. The spacing between dispatches must equal the latest delay plus three. The read addresses must keep counting upward without a restart. The finished pulse must follow the terminating word exactly.

// File: rtl/layer_seq_pkg.sv
package layer_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_FETCH    = 3'd1,
      ST_DECODE   = 3'd2,
      ST_DISPATCH = 3'd3,
      ST_WAIT_ALL = 3'd4,
      ST_DONE     = 3'd5
   } seq_state_t;

   localparam int N_WORKERS = 3;
   localparam int W_READER  = 0;
   localparam int W_PE      = 1;
   localparam int W_WRITER  = 2;

endpackage

// File: rtl/layer_seq_pc.sv
module layer_seq_pc #(
   parameter int ADDR_W     = 8,
   parameter int START_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [ADDR_W-1:0] pc
);
   localparam logic [ADDR_W-1:0] START_VAL = ADDR_W'(START_ADDR);

   if (START_ADDR < 0 || START_ADDR >= (1 << ADDR_W)) begin : g_bad_start
      $error("START_ADDR outside the address range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pc <= START_VAL;
      else if (load) pc <= START_VAL;
      else if (step) pc <= pc + 1'b1;
   end

   // The program counter advances by exactly one per dispatched word (R2).
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (pc == $past(pc) + 1'b1));

   assert_pc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pc == START_VAL));
endmodule

// File: rtl/layer_seq_decode.sv
module layer_seq_decode #(
   parameter int          INSTR_W   = 512,
   parameter int          OP_W      = 8,
   parameter int          FIELD_W   = 160,
   parameter bit          OP_AT_TOP = 1'b0,
   parameter logic [7:0]  END_OP    = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [INSTR_W-1:0] word,
   output logic               is_end,
   output logic [FIELD_W-1:0] rd_field,
   output logic [FIELD_W-1:0] pe_field,
   output logic [FIELD_W-1:0] wr_field
);
   localparam int USED_W = OP_W + 3 * FIELD_W;

   if (USED_W > INSTR_W) begin : g_bad_width
      $error("opcode and three fields do not fit the control word");
   end
   if (OP_W > 8) begin : g_bad_op
      $error("OP_W wider than the terminating code");
   end

   logic [OP_W-1:0]    op_now;
   logic [FIELD_W-1:0] rd_now, pe_now, wr_now;

   if (OP_AT_TOP) begin : g_op_top
      assign op_now = word[INSTR_W-1 -: OP_W];
      assign rd_now = word[0 +: FIELD_W];
      assign pe_now = word[FIELD_W +: FIELD_W];
      assign wr_now = word[2*FIELD_W +: FIELD_W];
   end else begin : g_op_bottom
      assign op_now = word[OP_W-1:0];
      assign rd_now = word[OP_W +: FIELD_W];
      assign pe_now = word[OP_W + FIELD_W +: FIELD_W];
      assign wr_now = word[OP_W + 2*FIELD_W +: FIELD_W];
   end

   assign is_end = (op_now == END_OP[OP_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_field <= '0;
         pe_field <= '0;
         wr_field <= '0;
      end else if (capture) begin
         rd_field <= rd_now;
         pe_field <= pe_now;
         wr_field <= wr_now;
      end
   end

   // Fields stay frozen between captures, so a worker may sample late (R3).
   assert_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rd_field) && $stable(pe_field) && $stable(wr_field));
endmodule

// File: rtl/layer_seq_barrier.sv
module layer_seq_barrier #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         armed,
   input  logic [N-1:0] done,
   output logic [N-1:0] mask,
   output logic         all_done
);
   if (N < 1) begin : g_bad_n
      $error("barrier needs at least one worker");
   end

   logic [N-1:0] seen;

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign seen[i] = mask[i] | done[i];
      always_ff @(posedge clk) begin
         if (!rst_n || clear) mask[i] <= 1'b0;
         else if (armed)      mask[i] <= seen[i];
      end
   end

   assign all_done = armed && (&seen);

   // A fresh dispatch empties the mask (R5).
   assert_mask_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (mask == '0));

   // Done lines outside the waiting window leave the mask untouched (R6).
   assert_idle_done_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !clear) |=> $stable(mask));
endmodule

// File: rtl/layer_seq_ctrl.sv
module layer_seq_ctrl
   import layer_seq_pkg::*;
#(
   parameter int          INSTR_W    = 512,
   parameter int          ADDR_W     = 8,
   parameter int          OP_W       = 8,
   parameter int          FIELD_W    = 160,
   parameter bit          OP_AT_TOP  = 1'b0,
   parameter logic [7:0]  END_OP     = 8'hFF,
   parameter int          START_ADDR = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   output logic               imem_rd_o,
   output logic [ADDR_W-1:0]  imem_addr_o,
   input  logic [INSTR_W-1:0] imem_data_i,
   output logic               rd_valid_o,
   output logic [FIELD_W-1:0] rd_field_o,
   output logic               pe_valid_o,
   output logic [FIELD_W-1:0] pe_field_o,
   output logic               wr_valid_o,
   output logic [FIELD_W-1:0] wr_field_o,
   input  logic               rd_done_i,
   input  logic               pe_done_i,
   input  logic               wr_done_i,
   output logic               finished_o
);
   seq_state_t state, state_nx;

   logic                 pc_load, pc_step, capture, word_end;
   logic                 bar_clear, bar_armed, bar_all;
   logic [N_WORKERS-1:0] done_vec, bar_mask;
   logic [ADDR_W-1:0]    pc;

   always_comb begin
      done_vec           = '0;
      done_vec[W_READER] = rd_done_i;
      done_vec[W_PE]     = pe_done_i;
      done_vec[W_WRITER] = wr_done_i;
   end

   layer_seq_pc #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_pc (
      .clk(clk), .rst_n(rst_n), .load(pc_load), .step(pc_step), .pc(pc)
   );

   layer_seq_decode #(
      .INSTR_W(INSTR_W), .OP_W(OP_W), .FIELD_W(FIELD_W),
      .OP_AT_TOP(OP_AT_TOP), .END_OP(END_OP)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .capture(capture), .word(imem_data_i),
      .is_end(word_end), .rd_field(rd_field_o), .pe_field(pe_field_o),
      .wr_field(wr_field_o)
   );

   layer_seq_barrier #(.N(N_WORKERS)) u_bar (
      .clk(clk), .rst_n(rst_n), .clear(bar_clear), .armed(bar_armed),
      .done(done_vec), .mask(bar_mask), .all_done(bar_all)
   );

   always_comb begin
      state_nx  = state;
      pc_load   = 1'b0;
      pc_step   = 1'b0;
      capture   = 1'b0;
      bar_clear = 1'b0;
      bar_armed = 1'b0;
      unique case (state)
         ST_IDLE: if (start_i) begin
            pc_load  = 1'b1;
            state_nx = ST_FETCH;
         end
         ST_FETCH:  state_nx = ST_DECODE;
         ST_DECODE: begin
            capture  = ~word_end;
            state_nx = word_end ? ST_DONE : ST_DISPATCH;
         end
         ST_DISPATCH: begin
            bar_clear = 1'b1;
            pc_step   = 1'b1;
            state_nx  = ST_WAIT_ALL;
         end
         ST_WAIT_ALL: begin
            bar_armed = 1'b1;
            if (bar_all) state_nx = ST_FETCH;
         end
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign imem_rd_o   = (state == ST_FETCH);
   assign imem_addr_o = pc;
   assign rd_valid_o  = (state == ST_DISPATCH);
   assign pe_valid_o  = (state == ST_DISPATCH);
   assign wr_valid_o  = (state == ST_DISPATCH);
   assign finished_o  = (state == ST_DONE);

   // R1: quiet outputs in the first cycle after reset.
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !imem_rd_o && !rd_valid_o && !finished_o);

   // R4: each start pulse lasts one cycle.
   assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |=> !rd_valid_o && !pe_valid_o && !wr_valid_o);

   // R4: dispatch comes two cycles after a read.
   assert_valid_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid_o) |-> $past(imem_rd_o, 2));

   // R5: a read that follows a wait happens only once every worker is seen.
   assert_fetch_after_barrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (imem_rd_o && $past(state) == ST_WAIT_ALL) |-> $past(&(bar_mask | done_vec)));

   // R7: finished is a single pulse and never overlaps a dispatch.
   assert_finish_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      finished_o |=> !finished_o && !rd_valid_o);

   // R6: no read is issued straight out of idle without a start.
   assert_idle_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_IDLE && !$past(start_i)) |-> !imem_rd_o);
endmodule

// File: tb/test_layer_seq_ctrl.sv
module test_layer_seq_ctrl;
   localparam int IW = 512;
   localparam int FW = 160;
   localparam int NOPS = 4;
   // per-entry delays: reader [11:8], PE [7:4], writer [3:0]
   localparam logic [11:0] DLY [NOPS] = '{12'h111, 12'h523, 12'h272, 12'h339};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic imem_rd_o, rd_valid_o, pe_valid_o, wr_valid_o, finished_o;
   logic [7:0] imem_addr_o;
   logic [IW-1:0] imem_data_i;
   logic [FW-1:0] rd_field_o, pe_field_o, wr_field_o;
   logic [2:0] mdone = '0;
   logic [2:0] stray = '0;
   logic [IW-1:0] mem [16];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int fetch_run = 0, disp_cnt = 0, fin_cnt = 0, last_disp = 0, prev_d = 0;
   logic run_disp = 1'b0;
   logic was_valid = 1'b0;
   int rcnt = 0, pcnt = 0, wcnt = 0;

   always #2 clk = ~clk;

   layer_seq_ctrl i_layer_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .imem_rd_o(imem_rd_o), .imem_addr_o(imem_addr_o), .imem_data_i(imem_data_i),
      .rd_valid_o(rd_valid_o), .rd_field_o(rd_field_o),
      .pe_valid_o(pe_valid_o), .pe_field_o(pe_field_o),
      .wr_valid_o(wr_valid_o), .wr_field_o(wr_field_o),
      .rd_done_i(mdone[0] | stray[0]), .pe_done_i(mdone[1] | stray[1]),
      .wr_done_i(mdone[2] | stray[2]), .finished_o(finished_o)
   );

   always_ff @(posedge clk) begin
      if (imem_rd_o) imem_data_i <= mem[imem_addr_o[3:0]];
      cyc <= cyc + 1;
   end

   function automatic logic [FW-1:0] fexp(int k, int w);
      return {20{8'(k * 16 + w + 1)}};
   endfunction

   function automatic int maxd(int k);
      int a = int'(DLY[k][11:8]);
      if (int'(DLY[k][7:4]) > a) a = int'(DLY[k][7:4]);
      if (int'(DLY[k][3:0]) > a) a = int'(DLY[k][3:0]);
      return a;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // worker models: done arrives 'delay' cycles after the valid pulse
   always @(negedge clk) begin
      mdone <= '0;
      if (rd_valid_o && disp_cnt < NOPS) begin
         rcnt <= int'(DLY[disp_cnt][11:8]);
         pcnt <= int'(DLY[disp_cnt][7:4]);
         wcnt <= int'(DLY[disp_cnt][3:0]);
      end else begin
         if (rcnt != 0) begin rcnt <= rcnt - 1; if (rcnt == 1) mdone[0] <= 1'b1; end
         if (pcnt != 0) begin pcnt <= pcnt - 1; if (pcnt == 1) mdone[1] <= 1'b1; end
         if (wcnt != 0) begin wcnt <= wcnt - 1; if (wcnt == 1) mdone[2] <= 1'b1; end
      end
   end

   // port monitor
   always @(negedge clk) begin
      if (rst_n) begin
         was_valid <= rd_valid_o;
         if (imem_rd_o) begin
            chk(imem_addr_o == 8'(fetch_run), "R2", "read address", imem_addr_o, fetch_run);
            fetch_run <= fetch_run + 1;
         end
         if (rd_valid_o || pe_valid_o || wr_valid_o) begin
            chk(rd_valid_o && pe_valid_o && wr_valid_o, "R4", "valids together",
                {rd_valid_o, pe_valid_o, wr_valid_o}, 7);
            chk(!was_valid, "R4", "single-cycle valid", was_valid, 0);
            chk(rd_field_o == fexp(disp_cnt, 0), "R3", "reader field", rd_field_o[7:0], fexp(disp_cnt, 0) & 8'hFF);
            chk(pe_field_o == fexp(disp_cnt, 1), "R3", "pe field", pe_field_o[7:0], fexp(disp_cnt, 1) & 8'hFF);
            chk(wr_field_o == fexp(disp_cnt, 2), "R3", "writer field", wr_field_o[7:0], fexp(disp_cnt, 2) & 8'hFF);
            if (run_disp)
               chk(cyc - last_disp == prev_d + 3, "R5", "dispatch spacing", cyc - last_disp, prev_d + 3);
            if (disp_cnt < NOPS) prev_d <= maxd(disp_cnt);
            last_disp <= cyc;
            disp_cnt  <= disp_cnt + 1;
            run_disp  <= 1'b1;
         end
         if (finished_o) begin
            chk(!rd_valid_o, "R7", "no valid with finish", rd_valid_o, 0);
            if (run_disp)
               chk(cyc - last_disp == prev_d + 3, "R7", "finish spacing", cyc - last_disp, prev_d + 3);
            fin_cnt   <= fin_cnt + 1;
            run_disp  <= 1'b0;
            fetch_run <= 0;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int fin0, disp0, k;
      logic mid_sent;
      for (int i = 0; i < 16; i++) mem[i] = '0;
      for (int i = 0; i < NOPS; i++)
         mem[i] = {24'b0, fexp(i, 2), fexp(i, 1), fexp(i, 0), 8'(i + 1)};
      mem[NOPS] = {{(IW-8){1'b0}}, 8'hFF};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!imem_rd_o, "R1", "read in reset", imem_rd_o, 0);
      chk(!rd_valid_o && !pe_valid_o && !wr_valid_o, "R1", "valid in reset", rd_valid_o, 0);
      chk(!finished_o, "R1", "finished in reset", finished_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!imem_rd_o && !rd_valid_o && !finished_o, "R1", "quiet after reset", imem_rd_o, 0);

      // vector-table program with a spurious start in the middle (R2, R5)
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      mid_sent = 1'b0;
      while (fin_cnt == 0) begin
         @(negedge clk);
         if (disp_cnt == 2 && !mid_sent) begin start_i = 1'b1; mid_sent = 1'b1; end
         else start_i = 1'b0;
      end
      @(negedge clk);
      chk(disp_cnt == NOPS, "R2", "dispatch count", disp_cnt, NOPS);
      chk(fin_cnt == 1, "R7", "finish count", fin_cnt, 1);
      chk(!finished_o, "R7", "finish single pulse", finished_o, 0);

      // R6: stray done lines while idle
      stray = 3'b111;
      repeat (3) @(negedge clk);
      stray = 3'b000;
      for (int i = 0; i < 5; i++) begin
         chk(!imem_rd_o && !rd_valid_o && !finished_o, "R6", "idle after stray done",
             {imem_rd_o, rd_valid_o, finished_o}, 0);
         @(negedge clk);
      end

      // R7: program whose first word terminates, restarted from idle
      mem[0] = {{(IW-8){1'b0}}, 8'hFF};
      fin0 = fin_cnt;
      disp0 = disp_cnt;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      k = 1;
      while (!finished_o && k < 20) begin
         @(negedge clk);
         k++;
      end
      chk(k == 3, "R7", "finish latency", k, 3);
      @(negedge clk);
      chk(fin_cnt == fin0 + 1, "R7", "second finish", fin_cnt, fin0 + 1);
      chk(disp_cnt == disp0, "R7", "no dispatch on end word", disp_cnt, disp0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule